// File: doc/BRIEF.md
# Packed Lane Shift-Accumulate Unit

This block is a packed-vector datapath for a signed shift-right-and-add operation. It takes one 32-bit decoded instruction word, a 128-bit source vector and a 128-bit accumulator vector. Both vectors are split into equal lanes of 8, 16, 32 or 64 bits. In every lane, the source value is shifted right arithmetically by an immediate amount. The shifted value is then added to the accumulator lane in the same position. Each lane sum wraps within its own lane width. No carry crosses a lane boundary, and no flags are produced.

The lane size and the shift amount are both taken from one packed 7-bit immediate, formed by a 4-bit high part and a 3-bit low part. A width bit chooses between a 64-bit vector and a 128-bit vector. Operands are accepted on a valid/ready handshake. The result is held in an output register with its own valid signal, together with the destination register index and an illegal-encoding indication. A downstream stage that is not ready stalls the unit.

Top module: `lane_shacc`

## Requirements
- R1: Each source lane is shifted right arithmetically: every vacated high bit takes the value of that lane's sign bit (the lane's top bit).
- R2: The shifted lane value is added to the accumulator lane in the same position, and the sum is that lane of `out_result`.
- R3: The shift truncates toward minus infinity and adds no rounding constant: a lane holding -3 shifted by 1 gives -2, and a lane holding 3 gives 1.
- R4: Each lane sum keeps only its low lane-width bits. Overflow wraps inside the lane, and no carry passes into the neighbouring lane.
- R5: The lane size comes from the highest set bit of the high immediate part, `in_instr[22:19]`: 0001 gives 8 bits, 001x gives 16 bits, 01xx gives 32 bits and 1xxx gives 64 bits.
- R6: The shift amount is twice the lane size minus the 7-bit value `in_instr[22:16]`. It ranges from 1 to the lane size. A shift equal to the lane size gives 0 or -1 for that lane before the add.
- R7: `in_instr[30]` selects the vector width. When it is 0, only the low 64 bits are processed and `out_result[127:64]` is zero. When it is 1, all 128 bits are processed.
- R8: These encodings are illegal: `in_instr[22:19]` = 0000, and `in_instr[22:19]` = 1xxx with `in_instr[30]` = 0. For an illegal encoding, `out_illegal` is 1, `out_we` is 0 and `out_result` is zero. For any legal encoding, `out_illegal` is 0 and `out_we` is 1.
- R9: The operands are captured on a clock edge where `in_valid` and `in_ready` are both high. `out_valid` is high from the next edge onward, and `out_rd` equals the captured `in_instr[4:0]`.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all outputs hold their values.
- R11: A synchronous active-low reset clears `out_valid`. After reset, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Unit can capture an operand set this cycle |
| in_instr | input | 32 | Decoded instruction word (width bit, immediate, destination index) |
| in_src | input | 128 | Source vector to shift |
| in_acc | input | 128 | Accumulator vector |
| out_valid | output | 1 | Result register holds an untaken result |
| out_ready | input | 1 | Downstream takes the result |
| out_result | output | 128 | Lane-wise accumulated result |
| out_we | output | 1 | Destination should be written |
| out_illegal | output | 1 | Instruction encoding is illegal |
| out_rd | output | 5 | Destination register index |

## Verification
The unit has one register stage. A result is due on the clock edge right after the edge that captured its operands, and it stays there until the edge on which `out_ready` is high. The driver records the expected result in a queue only at the moment it sees `in_ready` high while it offers an item. The monitor samples 1 ns after each falling edge, and on every cycle with `out_valid` and `out_ready` both high it removes one entry from the queue and compares it, so the check lands exactly on the cycle in which the result is taken. A directed single-item case also confirms that `out_valid` is already high at the first falling edge after capture. During random backpressure, each stalled cycle is compared with the stalled cycle before it, to confirm that the outputs hold and `in_ready` stays low.

// File: rtl/lane_shacc_pkg.sv
// Package: shared types for the packed lane shift-accumulate unit.
// Assumes: the instruction layout is fixed (width bit 30, immediate 22:16,
// destination index 4:0); only the vector width is a parameter elsewhere.
package lane_shacc_pkg;

    // Lane size code; the numeric value n means 8 << n bits per lane.
    typedef enum logic [1:0] {
        LANE_8  = 2'd0,
        LANE_16 = 2'd1,
        LANE_32 = 2'd2,
        LANE_64 = 2'd3
    } lane_sz_e;

    localparam int NUM_SIZES = 4;
    localparam int SHAMT_W   = 7;
    localparam int IMM_W     = 7;
    localparam int RD_W      = 5;
    localparam int INSTR_W   = 32;

    // Bit positions inside the instruction word
    localparam int WIDE_BIT  = 30;
    localparam int IMM_HI_LO = 19;
    localparam int IMM_LO_LO = 16;

    // Decoded control for one operation
    typedef struct packed {
        lane_sz_e               sz;
        logic [SHAMT_W-1:0]     shamt;
        logic                   wide;
        logic                   illegal;
        logic [RD_W-1:0]        rd;
    } shacc_ctl_t;

endpackage

// File: rtl/shacc_decode.sv
// Module: shacc_decode
// Purpose: turns the instruction word into lane size, shift amount, width
// select, destination index and an illegal-encoding flag.
// Assumes: instr is already known to be of this operation class; only the
// immediate and width fields are checked for legality. clk/rst_n serve the
// local assertions only.
module shacc_decode
    import lane_shacc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    output shacc_ctl_t         ctl
);

    logic [3:0]       imm_hi;
    logic [2:0]       imm_lo;
    logic [IMM_W-1:0] imm_all;
    logic             wide;
    lane_sz_e         sz;
    logic [7:0]       lane_bits;
    logic [7:0]       shamt_full;
    logic             unused_fields;

    assign imm_hi  = instr[IMM_HI_LO +: 4];
    assign imm_lo  = instr[IMM_LO_LO +: 3];
    assign imm_all = {imm_hi, imm_lo};
    assign wide    = instr[WIDE_BIT];

    // Fold fields this unit does not consume into one ignored net
    assign unused_fields = ^{instr[31], instr[29:23], instr[15:5]};

    // Lane size follows the highest set bit of the high immediate part
    always_comb begin
        casez (imm_hi)
            4'b1???: sz = LANE_64;
            4'b01??: sz = LANE_32;
            4'b001?: sz = LANE_16;
            default: sz = LANE_8;
        endcase
    end

    // Shift amount is twice the lane width minus the whole immediate
    always_comb begin
        lane_bits  = 8'd8 << sz;
        shamt_full = (lane_bits << 1) - {1'b0, imm_all};
    end

    // Collect the decoded control word
    always_comb begin
        ctl.sz      = sz;
        ctl.shamt   = shamt_full[SHAMT_W-1:0];
        ctl.wide    = wide;
        ctl.illegal = (imm_hi == 4'b0000) || (imm_hi[3] && !wide);
        ctl.rd      = instr[RD_W-1:0];
    end

    // R6
    shamt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.illegal |-> (ctl.shamt >= 7'd1) &&
                         ({1'b0, ctl.shamt} <= lane_bits));

    // R8
    zero_imm_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[IMM_HI_LO +: 4] == 4'b0000) |-> ctl.illegal);

    // R5
    size_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr[IMM_HI_LO + 3] |-> (ctl.sz == LANE_64));

endmodule

// File: rtl/shacc_lane.sv
// Module: shacc_lane
// Purpose: one lane: arithmetic right shift of src, then wrap-around add
// onto acc.
// Assumes: shamt is at most LANE_W when this lane's size is the selected
// one; larger values only occur when the output is discarded.
module shacc_lane #(
    parameter int LANE_W  = 8,
    parameter int SHAMT_W = 7
) (
    input  logic [LANE_W-1:0]  src,
    input  logic [LANE_W-1:0]  acc,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [LANE_W-1:0]  sum
);

    logic signed [LANE_W:0] ext;
    logic signed [LANE_W:0] shifted;

    // One extra sign bit lets a full-width shift still yield pure sign fill
    always_comb begin
        ext     = $signed({src[LANE_W-1], src});
        shifted = ext >>> shamt;
        sum     = acc + shifted[LANE_W-1:0];
    end

endmodule

// File: rtl/shacc_lanes.sv
// Module: shacc_lanes
// Purpose: builds one lane array per lane size and selects the array that
// matches the decoded size.
// Assumes: VEC_W is a multiple of 64.
module shacc_lanes
    import lane_shacc_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0]   src,
    input  logic [VEC_W-1:0]   acc,
    input  lane_sz_e           sz,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [VEC_W-1:0]   result
);

    logic [VEC_W-1:0] by_size [NUM_SIZES];

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        localparam int LW    = 8 << g;
        localparam int LANES = VEC_W / LW;
        logic [VEC_W-1:0] vec;

        for (genvar l = 0; l < LANES; l++) begin : g_lane
            shacc_lane #(
                .LANE_W  (LW),
                .SHAMT_W (SHAMT_W)
            ) u_lane (
                .src   (src[l*LW +: LW]),
                .acc   (acc[l*LW +: LW]),
                .shamt (shamt),
                .sum   (vec[l*LW +: LW])
            );
        end

        assign by_size[g] = vec;
    end

    // Pick the lane array for the decoded size
    always_comb begin
        result = by_size[sz];
    end

endmodule

// File: rtl/lane_shacc.sv
// Module: lane_shacc (top)
// Purpose: packed signed shift-right-and-accumulate over 8/16/32/64-bit
// lanes, with an input valid/ready handshake and one output register stage.
// Assumes: synchronous active-low reset; the caller supplies the source and
// accumulator vectors that the instruction names.
module lane_shacc
    import lane_shacc_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [31:0]        in_instr,
    input  logic [VEC_W-1:0]   in_src,
    input  logic [VEC_W-1:0]   in_acc,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [VEC_W-1:0]   out_result,
    output logic               out_we,
    output logic               out_illegal,
    output logic [4:0]         out_rd
);

    localparam int HALF_W = VEC_W / 2;

    shacc_ctl_t       ctl;
    logic [VEC_W-1:0] lanes_sum;
    logic [VEC_W-1:0] shaped;
    logic             take;
    logic             res_wide;

    shacc_decode u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .instr (in_instr),
        .ctl   (ctl)
    );

    shacc_lanes #(
        .VEC_W (VEC_W)
    ) u_lanes (
        .src    (in_src),
        .acc    (in_acc),
        .sz     (ctl.sz),
        .shamt  (ctl.shamt),
        .result (lanes_sum)
    );

    // Zero the whole result when illegal, the high half when narrow
    always_comb begin
        if (ctl.illegal)
            shaped = '0;
        else if (!ctl.wide)
            shaped = {{HALF_W{1'b0}}, lanes_sum[HALF_W-1:0]};
        else
            shaped = lanes_sum;
    end

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    // Output valid: set on capture, cleared when taken with nothing new
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else if (take)
            out_valid <= 1'b1;
        else if (out_ready)
            out_valid <= 1'b0;
    end

    // Output data: loaded only on capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result  <= '0;
            out_we      <= 1'b0;
            out_illegal <= 1'b0;
            out_rd      <= '0;
            res_wide    <= 1'b0;
        end else if (take) begin
            out_result  <= shaped;
            out_we      <= !ctl.illegal;
            out_illegal <= ctl.illegal;
            out_rd      <= ctl.rd;
            res_wide    <= ctl.wide;
        end
    end

    // R9
    accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R9
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_rd == $past(in_instr[4:0])));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_result) &&
                                      $stable(out_rd) && $stable(out_we));

    // R8
    illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> !out_we && (out_result == '0));

    // R7
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !res_wide) |-> (out_result[VEC_W-1:HALF_W] == '0));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

// File: tb/lane_shacc_bench.sv
`timescale 1ns/1ps
module lane_shacc_bench;

    typedef struct {
        logic [127:0] res;
        logic         ill;
        logic [4:0]   rd;
        string        req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_instr = '0;
    logic [127:0] in_src = '0;
    logic [127:0] in_acc = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_result;
    logic         out_we;
    logic         out_illegal;
    logic [4:0]   out_rd;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit bp_en = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    lane_shacc u_lane_shacc (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_instr(in_instr),
        .in_src(in_src), .in_acc(in_acc),
        .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
        .out_we(out_we), .out_illegal(out_illegal), .out_rd(out_rd)
    );

    function automatic logic [31:0] mk(input bit q, input logic [3:0] hi,
                                       input logic [2:0] lo, input logic [4:0] rd);
        return 32'h0F00_1400 | (32'(q) << 30) | (32'(hi) << 19) |
               (32'(lo) << 16) | 32'(rd);
    endfunction

    // Reference: built from the requirements (R1..R8)
    function automatic exp_t model(input logic [31:0] ins, input logic [127:0] s,
                                   input logic [127:0] a, input string req);
        exp_t e;
        logic [3:0] hi = ins[22:19];
        bit q = ins[30];
        int w, sh, n;
        logic signed [127:0] sv;
        logic [127:0] lane_v, lane_a, sum;
        e.res = '0; e.rd = ins[4:0]; e.req = req;
        e.ill = (hi == 4'd0) || (hi[3] && !q);
        if (e.ill) return e;
        if (hi >= 4'd8) w = 64; else if (hi >= 4'd4) w = 32;
        else if (hi >= 4'd2) w = 16; else w = 8;
        sh = 2 * w - int'(ins[22:16]);
        n = (q ? 128 : 64) / w;
        for (int l = 0; l < n; l++) begin
            lane_v = '0; lane_a = '0;
            for (int b = 0; b < w; b++) begin
                lane_v[b] = s[l*w + b];
                lane_a[b] = a[l*w + b];
            end
            for (int b = 0; b < 128; b++) sv[b] = (b < w) ? lane_v[b] : lane_v[w-1];
            sv = sv >>> sh;
            sum = lane_a + sv;
            for (int b = 0; b < w; b++) e.res[l*w + b] = sum[b];
        end
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic send(input logic [31:0] ins, input logic [127:0] s,
                        input logic [127:0] a, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_instr = ins; in_src = s; in_acc = a;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        sb.push_back(model(ins, s, a, req));
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: pops one expected item per accepted result; checks stalls
    logic         stall_prev = 1'b0;
    logic [127:0] held = '0;
    logic [4:0]   held_rd = '0;
    initial begin
        exp_t e;
        forever begin
            @(negedge clk); #1;
            if (rst_n) begin
                if (stall_prev) begin
                    // R10 outputs hold while stalled
                    check(out_valid && out_result == held && out_rd == held_rd,
                          "R10", "stall hold", out_result, held);
                end
                if (out_valid && !out_ready)
                    check(!in_ready, "R10", "in_ready low in stall",
                          128'(in_ready), 128'(0));
                if (out_valid && out_ready) begin
                    if (sb.size() == 0) begin
                        check(0, "R9", "result with empty scoreboard", out_result, 0);
                    end else begin
                        e = sb.pop_front();
                        check(out_result == e.res, e.req, "result", out_result, e.res);
                        check(out_illegal == e.ill && out_we == !e.ill, "R8",
                              "illegal/we", {out_illegal, out_we}, {e.ill, !e.ill});
                        check(out_rd == e.rd, "R9", "rd", 128'(out_rd), 128'(e.rd));
                    end
                end
                stall_prev = out_valid && !out_ready;
                held = out_result;
                held_rd = out_rd;
            end
        end
    end

    // Downstream readiness: random when backpressure is enabled
    initial begin
        forever begin
            @(negedge clk);
            out_ready = bp_en ? (($urandom % 4) != 0) : 1'b1;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [127:0] s, a;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        check(!out_valid && in_ready, "R11", "reset state",
              {out_valid, in_ready}, 2'b01);

        // R9 latency: one item, valid at the first falling edge after capture
        send(mk(1, 4'b0001, 3'b111, 5'd7), {16{8'h10}}, {16{8'h01}}, "R2");
        @(negedge clk); in_valid = 1'b0; #1;
        check(out_valid, "R9", "valid one cycle after capture", 128'(out_valid), 1);
        idle();

        // R1 R6: 8-bit lanes, shift 8 -> sign fill, added to acc
        send(mk(1, 4'b0001, 3'b000, 5'd1), {8{8'h80, 8'h7F}}, {16{8'h05}}, "R1");
        // R3: -3 >> 1 = -2 and 3 >> 1 = 1 (16-bit shift 1: imm 31)
        send(mk(1, 4'b0011, 3'b111, 5'd2), {4{16'hFFFD, 16'h0003}}, '0, "R3");
        // R4: 8-bit lanes 0x7F + (2>>1) wrap to 0x80 with no carry
        send(mk(1, 4'b0001, 3'b111, 5'd3), {16{8'h02}}, {16{8'h7F}}, "R4");
        // R4: 16-bit wrap 0xFFFF + 1 stays in lane
        send(mk(1, 4'b0011, 3'b111, 5'd4), {8{16'h0002}}, {8{16'hFFFF}}, "R4");
        // R5: 16-bit shift 3 (imm 29)
        send(mk(1, 4'b0011, 3'b101, 5'd5), {8{16'h8421}}, {8{16'h1111}}, "R5");
        // R5 R6: 32-bit shift 32 (imm 32) -> 0 / -1 per lane
        send(mk(1, 4'b0100, 3'b000, 5'd6), {32'h8000_0000, 32'h7FFF_FFFF,
             32'hFFFF_FFFF, 32'h0000_0001}, {4{32'h0000_0010}}, "R6");
        // R5: 64-bit shift 1 (imm 127)
        send(mk(1, 4'b1111, 3'b111, 5'd8), {64'h8000_0000_0000_0003,
             64'h7FFF_FFFF_FFFF_FFFF}, {2{64'h1}}, "R5");
        // R6: 64-bit shift 64 (imm 64)
        send(mk(1, 4'b1000, 3'b000, 5'd9), {64'h8000_0000_0000_0000,
             64'h1234_0000_0000_0000}, {2{64'h10}}, "R6");
        // R7: narrow vector, 16-bit lanes, upper half zero
        send(mk(0, 4'b0010, 3'b100, 5'd10), {8{16'hC003}}, {8{16'h0101}}, "R7");
        // R8: 64-bit lanes with narrow width -> illegal
        send(mk(0, 4'b1010, 3'b001, 5'd11), {2{64'hFFFF}}, {2{64'h1}}, "R8");
        // R8: zero high immediate -> illegal
        send(mk(1, 4'b0000, 3'b101, 5'd12), {2{64'hFFFF}}, {2{64'h1}}, "R8");
        idle();

        // Random traffic with backpressure (R2 R4 R5 R6 R7 R10)
        bp_en = 1;
        for (int i = 0; i < 300; i++) begin
            int g, w, sh;
            bit q;
            logic [6:0] imm;
            g = $urandom % 4;
            w = 8 << g;
            sh = 1 + ($urandom % w);
            q = (g == 3) ? 1'b1 : 1'($urandom);
            imm = 7'(2 * w - sh);
            if (($urandom % 16) == 0) q = 1'b0;
            s = {$urandom, $urandom, $urandom, $urandom};
            a = {$urandom, $urandom, $urandom, $urandom};
            send(mk(q, imm[6:3], imm[2:0], 5'($urandom)), s, a, "R2");
            if (($urandom % 5) == 0) idle();
        end
        idle();
        bp_en = 0;
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule